// File: doc/BRIEF.md
# Flash Programming Control Register

This block is a processor-visible byte register that decides when on-chip flash may be programmed or erased. It holds a program-write enable, a mass-erase enable, a sticky read-protection bit, and a read-only view of the preboot status. While the program-write enable is set, the core's external-memory store through the data pointer is steered into program flash instead of data RAM. The flash controller reads the enable levels from this block's outputs.

Both operation enables clear themselves once their operation is finished. The program-write enable drops after each byte the flash controller reports as written. The mass-erase enable drops when the controller reports the end of an erase cycle. Software must therefore re-arm an enable before every operation. Writes to the program-write enable are ignored while the global interrupt enable is high. The protection bit can be set by software and is cleared only by chip reset. While it is set, the block drives an output that blocks external read-out of flash and of the measurement engine's program RAM.

The register port is a plain write strobe with write data and a combinational read value. There is no handshake and no back-pressure: a strobed write always lands on the next clock edge. The completion pulses from the flash controller are single-cycle level inputs, not streams.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, read bits 6..0 are 0, read bit 7 equals `preboot_i`, and `prog_wr_en_o`, `mass_erase_en_o` and `secure_o` are low.
- R2: A write while `int_glob_en_i` is 0 loads write bit 0 into the program-write enable. The new value shows on read bit 0 and on `prog_wr_en_o` after the next clock edge.
- R3: While `int_glob_en_i` is 1, write bit 0 is ignored and the program-write enable keeps its value, whether that value is 0 or 1.
- R4: A `byte_done_i` pulse clears the program-write enable at the next edge. It takes priority over a write in the same cycle.
- R5: A write loads write bit 1 into the mass-erase enable (read bit 1, `mass_erase_en_o`) whatever the value of `int_glob_en_i`.
- R6: An `erase_done_i` pulse clears the mass-erase enable at the next edge. It takes priority over a write in the same cycle.
- R7: A write with bit 6 at 1 sets the protection bit (read bit 6, `secure_o`). A write with bit 6 at 0 leaves it unchanged, and only reset clears it.
- R8: Read bit 7 follows `preboot_i` in the same cycle. Write bit 7 has no effect.
- R9: Read bits 5..2 are always 0, and write bits 5..2 have no effect.
- R10: `byte_done_i` does not change the mass-erase enable, and `erase_done_i` does not change the program-write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset |
| wr_stb_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| int_glob_en_i | input | 1 | Global interrupt enable level |
| byte_done_i | input | 1 | Pulse: one byte written to flash |
| erase_done_i | input | 1 | Pulse: mass-erase cycle finished |
| preboot_i | input | 1 | Preboot sequence active |
| rd_data_o | output | 8 | Register read value |
| prog_wr_en_o | output | 1 | Stores go to program flash |
| mass_erase_en_o | output | 1 | Mass erase armed |
| secure_o | output | 1 | Block external read-out |

## Verification
Stored fields change at the clock edge that samples the write or the completion pulse. The bench drives each stimulus at a falling edge and compares the result at the following falling edge, exactly one edge later. Read bit 7 is combinational, so it is checked at the falling edge where `preboot_i` was driven, before any edge has passed. The sweep covers every write byte against every combination of interrupt enable and the two completion pulses. A model updated at the same edge supplies the expected values.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned PWE_POS    = 0;
  localparam int unsigned MEE_POS    = 1;
  localparam int unsigned RSV_LO     = 2;
  localparam int unsigned RSV_HI     = 5;
  localparam int unsigned SEC_POS    = 6;
  localparam int unsigned PBT_POS    = 7;
  localparam int unsigned RSV_W      = RSV_HI - RSV_LO + 1;
endpackage

// File: rtl/fpc_op_bit.sv
// One-shot operation enable: set by write, cleared when the operation ends.
module fpc_op_bit #(
  parameter bit GATED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic wr_val,
  input  logic gate,
  input  logic op_done,
  output logic q
);
  logic blocked;
  assign blocked = GATED & gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 q <= 1'b0;
    else if (op_done)           q <= 1'b0;
    else if (wr_stb && !blocked) q <= wr_val;
  end

  // R4 R6
  op_done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !q);
  // R3
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (GATED && gate && !op_done) |=> $stable(q));
  // R2 R5
  write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !(GATED && gate) && !op_done) |=> (q == $past(wr_val)));
endmodule

// File: rtl/fpc_sticky_bit.sv
// Set-only bit: software may set it, reset alone clears it.
module fpc_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic wr_val,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               q <= 1'b0;
    else if (wr_stb && wr_val) q <= 1'b1;
  end

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q |=> q);
  // R7
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_val) |=> q);
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import fpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             int_glob_en_i,
  input  logic             byte_done_i,
  input  logic             erase_done_i,
  input  logic             preboot_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             prog_wr_en_o,
  output logic             mass_erase_en_o,
  output logic             secure_o
);
  logic pwe_q, mee_q, sec_q;

  fpc_op_bit #(.GATED(1'b1)) u_pwe (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb_i), .wr_val(wr_data_i[PWE_POS]),
    .gate(int_glob_en_i), .op_done(byte_done_i), .q(pwe_q));

  fpc_op_bit #(.GATED(1'b0)) u_mee (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb_i), .wr_val(wr_data_i[MEE_POS]),
    .gate(1'b0), .op_done(erase_done_i), .q(mee_q));

  fpc_sticky_bit u_sec (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb_i), .wr_val(wr_data_i[SEC_POS]),
    .q(sec_q));

  always_comb begin
    rd_data_o                 = '0;
    rd_data_o[PWE_POS]        = pwe_q;
    rd_data_o[MEE_POS]        = mee_q;
    rd_data_o[RSV_HI:RSV_LO]  = {RSV_W{1'b0}};
    rd_data_o[SEC_POS]        = sec_q;
    rd_data_o[PBT_POS]        = preboot_i;
  end

  assign prog_wr_en_o    = pwe_q;
  assign mass_erase_en_o = mee_q;
  assign secure_o        = sec_q;

  // R10
  byte_done_keeps_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done_i && !wr_stb_i && !erase_done_i) |=> $stable(mass_erase_en_o));
  // R10
  erase_done_keeps_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_done_i && !wr_stb_i && !byte_done_i) |=> $stable(prog_wr_en_o));
endmodule

// File: tb/flash_prog_ctrl_tb.sv
module flash_prog_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       ie = 1'b0, bdone = 1'b0, edone = 1'b0, pboot = 1'b0;
  logic [7:0] rd;
  logic       pwe_o, mee_o, sec_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;
  logic m_pwe = 0, m_mee = 0, m_sec = 0;

  always #4 clk = ~clk;

  flash_prog_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb), .wr_data_i(wr_data),
    .int_glob_en_i(ie), .byte_done_i(bdone), .erase_done_i(edone),
    .preboot_i(pboot), .rd_data_o(rd), .prog_wr_en_o(pwe_o),
    .mass_erase_en_o(mee_o), .secure_o(sec_o));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 R3 R4 bit0",        {7'd0, rd[0]}, {7'd0, m_pwe});
    chk("R2 R4 prog_wr_en_o",   {7'd0, pwe_o}, {7'd0, m_pwe});
    chk("R5 R6 R10 bit1",       {7'd0, rd[1]}, {7'd0, m_mee});
    chk("R5 R6 mass_erase_en_o",{7'd0, mee_o}, {7'd0, m_mee});
    chk("R7 bit6",              {7'd0, rd[6]}, {7'd0, m_sec});
    chk("R7 secure_o",          {7'd0, sec_o}, {7'd0, m_sec});
    chk("R9 bits5..2",          {4'd0, rd[5:2]}, 8'd0);
    chk("R8 bit7",              {7'd0, rd[7]}, {7'd0, pboot});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=200000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    pboot = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset read", rd, 8'h80);
    chk("R1 reset outs", {5'd0, pwe_o, mee_o, sec_o}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", rd, 8'h80);

    for (int v = 0; v < 256; v++) begin
      for (int c = 0; c < 8; c++) begin
        wr_stb  = 1'b1;
        wr_data = v[7:0];
        ie      = c[0];
        bdone   = c[1];
        edone   = c[2];
        pboot   = v[2] ^ c[0];
        #1;
        chk("R8 same cycle", {7'd0, rd[7]}, {7'd0, pboot});
        if (bdone)        m_pwe = 1'b0;
        else if (!ie)     m_pwe = wr_data[0];
        if (edone)        m_mee = 1'b0;
        else              m_mee = wr_data[1];
        if (wr_data[6])   m_sec = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; bdone = 1'b0; edone = 1'b0;
        check_all();
      end
    end

    // R3 hold at 1 while interrupts enabled; R10 cross pulses
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    m_pwe = 0; m_mee = 0; m_sec = 0;
    chk("R7 reset clears", {7'd0, sec_o}, 8'd0);
    wr_stb = 1; wr_data = 8'h03; ie = 0; @(negedge clk);
    m_pwe = 1; m_mee = 1; check_all();
    wr_data = 8'h00; ie = 1; @(negedge clk);
    m_mee = 0; check_all();
    wr_stb = 0; edone = 1; @(negedge clk); edone = 0;
    check_all();
    bdone = 1; @(negedge clk); bdone = 0;
    m_pwe = 0; check_all();
    wr_stb = 1; wr_data = 8'h42; ie = 0; @(negedge clk);
    m_mee = 1; m_sec = 1; wr_stb = 0; check_all();
    bdone = 1; @(negedge clk); bdone = 0;
    check_all();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule